// File: doc/BRIEF.md
# DMA Descriptor Transfer Chunker

This block carries out the data movement for a single source descriptor of a DMA channel. A pulse on `start_i` captures the source address, byte count and completion flag, the first destination descriptor and the channel configuration. The block then cuts the byte count into transactions on a simple request/acknowledge memory port. Each transaction reads a chunk from the source into a staging buffer and drains it to the destination. The source address, the remaining sizes, the destination address and a running total-byte counter are updated as it goes.

Three transfer modes are selected by a 2-bit code. In read-write mode data is copied. In write-only mode a programmed data word is written and no reads are issued. In read-only mode reads are issued and nothing is written. Bursts either increment the address or hold it. With fixed bursts each transaction carries at most one bus width of data.

When descriptors come from memory rather than from registers, the configuration is forced to read-write with incrementing bursts. A destination descriptor may then run out before the source is consumed. In that case the block asks an external fetcher for the next one over a request/acknowledge handshake.

Top module: `dma_chunker`

## Requirements
- R1: A chunk length is the smallest of three values: the remaining source bytes, the 64-byte staging buffer, and the 8-byte bus width. The bus-width limit applies only with fixed bursts or in write-only mode. With incrementing bursts, the source and destination addresses advance by the bytes moved. A request holds its address, length and direction until acknowledged.
- R2: With fixed bursts (`burst_i` = 0), both addresses stay at their start values and no request exceeds 8 bytes. With incrementing bursts, `burst_i` = 1.
- R3: Write-only mode (`mode_i` = 1) takes its byte count from the destination size and ignores the source size. It issues no reads. Each written byte i of a chunk is byte (i mod 8) of `wo_data_i`, where byte k is bits 8k+7..8k.
- R4: Read-only mode (`mode_i` = 2) issues the source reads and no destination writes. Read-write mode has `mode_i` = 0.
- R5: With descriptors held in registers (`ptr_mem_i` = 0) and any mode other than write-only, the destination size input is ignored. Each chunk is written whole, and `dst_done_o` pulses after each chunk when `dst_intr_i` is set.
- R6: With descriptors held in memory (`ptr_mem_i` = 1), the mode and burst inputs are overridden to read-write and incrementing.
- R7: With descriptors held in memory, a destination descriptor may have zero bytes left while chunk data is still unwritten. The block then raises `dst_req_o` and loads address, size and flag on `dst_ack_i`. `dst_done_o` pulses when a write brings the destination remaining size to zero and that descriptor's flag is set.
- R8: `total_o` grows by each chunk's length once that chunk completes. Every bit set in `total_clr_i` clears the matching bit of the counter in that cycle, and zero bits leave it unchanged.
- R9: `done_o` pulses for one cycle when the source byte count is exhausted. A zero count finishes without any memory request. `src_done_o` pulses with it when the captured source flag is set.
- R10: In read-write mode with incrementing bursts, destination bytes equal the source bytes in order.
- R11: After reset the block is idle: no memory or fetch request, total zero, no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one source descriptor (accepted when idle) |
| mode_i | input | 2 | 0 read-write, 1 write-only, 2 read-only |
| burst_i | input | 1 | 0 fixed, 1 incrementing |
| ptr_mem_i | input | 1 | Descriptors held in memory |
| src_addr_i | input | 49 | Source start address |
| src_size_i | input | 30 | Source byte count |
| src_intr_i | input | 1 | Raise source-done at the end |
| dst_addr_i | input | 49 | First destination address |
| dst_size_i | input | 30 | First destination byte count |
| dst_intr_i | input | 1 | Destination-done flag of first descriptor |
| wo_data_i | input | 64 | Write-only data word |
| total_clr_i | input | 32 | Write-one-to-clear mask for the total counter |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 49 | Request address |
| mem_len_o | output | 7 | Request byte count |
| mem_wdata_o | output | 512 | Write data, byte 0 in bits 7..0 |
| mem_ack_i | input | 1 | Request completed |
| mem_rdata_i | input | 512 | Read data, valid with ack |
| dst_req_o | output | 1 | Next destination descriptor wanted |
| dst_ack_i | input | 1 | Next descriptor valid |
| dst_next_addr_i | input | 49 | Next destination address |
| dst_next_size_i | input | 30 | Next destination byte count |
| dst_next_intr_i | input | 1 | Next destination flag |
| busy_o | output | 1 | Descriptor in progress |
| done_o | output | 1 | Transfer-done pulse |
| src_done_o | output | 1 | Source-done pulse |
| dst_done_o | output | 1 | Destination-done pulse |
| src_addr_o | output | 49 | Current source address |
| src_rem_o | output | 30 | Source bytes left |
| dst_addr_o | output | 49 | Current destination address |
| dst_rem_o | output | 30 | Destination bytes left |
| total_o | output | 32 | Total-byte counter |

## Verification
The bench builds the block with its defaults: an 8-byte bus and a 64-byte staging buffer. With these values a 150-byte source splits into 64, 64 and 22 byte chunks. A 20-byte fixed or write-only transfer splits into 8, 8 and 4 bytes. Small sizes are therefore enough to reach the buffer limit, the bus-width limit and a destination that runs out part-way through a chunk. Memory-pointer cases use a 12-byte first descriptor so that one 20-byte chunk needs a descriptor fetch in the middle.

// File: rtl/dma_chunk_pkg.sv
`timescale 1ns/1ps
package dma_chunk_pkg;
  localparam logic [1:0] MODE_RW = 2'd0;
  localparam logic [1:0] MODE_WO = 2'd1;
  localparam logic [1:0] MODE_RO = 2'd2;
  localparam logic BURST_FIXED = 1'b0;
  localparam logic BURST_INCR  = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHUNK, ST_READ, ST_WCHK, ST_FETCH, ST_WRITE, ST_ACCT, ST_DONE
  } chunk_state_e;
endpackage

// File: rtl/dma_chunk_len.sv
`timescale 1ns/1ps
module dma_chunk_len #(
  parameter int SIZE_W    = 30,
  parameter int LEN_W     = 7,
  parameter int BUF_BYTES = 64,
  parameter int BUS_BYTES = 8
) (
  input  logic [SIZE_W-1:0] rem_i,
  input  logic              narrow_i,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [SIZE_W-1:0] BUF_LIM = SIZE_W'(BUF_BYTES);
  localparam logic [SIZE_W-1:0] BUS_LIM = SIZE_W'(BUS_BYTES);

  logic [SIZE_W-1:0] limit;
  assign limit = narrow_i ? BUS_LIM : BUF_LIM;
  assign len_o = (rem_i < limit) ? rem_i[LEN_W-1:0] : limit[LEN_W-1:0];
endmodule

// File: rtl/dma_chunk_total.sv
`timescale 1ns/1ps
module dma_chunk_total #(
  parameter int TOT_W = 32,
  parameter int LEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TOT_W-1:0] clr_i,
  input  logic             add_en_i,
  input  logic [LEN_W-1:0] add_i,
  output logic [TOT_W-1:0] total_o
);
  logic [TOT_W-1:0] total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) total_q <= '0;
    else         total_q <= (total_q & ~clr_i) + (add_en_i ? TOT_W'(add_i) : '0);
  end

  assign total_o = total_q;
endmodule

// File: rtl/dma_chunk_stage.sv
`timescale 1ns/1ps
module dma_chunk_stage #(
  parameter int BUF_BYTES = 64,
  parameter int BUS_BYTES = 8,
  parameter int LEN_W     = 7,
  localparam int BUF_W    = BUF_BYTES * 8,
  localparam int BUS_W    = BUS_BYTES * 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_rd_i,
  input  logic [BUF_W-1:0] rd_data_i,
  input  logic             load_pat_i,
  input  logic [BUS_W-1:0] pat_i,
  input  logic             shift_i,
  input  logic [LEN_W-1:0] shift_len_i,
  output logic [BUF_W-1:0] data_o
);
  logic [BUF_W-1:0] data_q;

  // drained bytes leave the bottom so the next write always starts at byte 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         data_q <= '0;
    else if (load_rd_i)  data_q <= rd_data_i;
    else if (load_pat_i) data_q <= BUF_W'(pat_i);
    else if (shift_i)    data_q <= data_q >> {shift_len_i, 3'b000};
  end

  assign data_o = data_q;
endmodule

// File: rtl/dma_chunker.sv
`timescale 1ns/1ps
module dma_chunker #(
  parameter int ADDR_W    = 49,
  parameter int SIZE_W    = 30,
  parameter int TOT_W     = 32,
  parameter int BUS_BYTES = 8,
  parameter int BUF_BYTES = 64,
  localparam int LEN_W    = $clog2(BUF_BYTES + 1),
  localparam int BUS_W    = BUS_BYTES * 8,
  localparam int BUF_W    = BUF_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              burst_i,
  input  logic              ptr_mem_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [SIZE_W-1:0] src_size_i,
  input  logic              src_intr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [SIZE_W-1:0] dst_size_i,
  input  logic              dst_intr_i,
  input  logic [BUS_W-1:0]  wo_data_i,
  input  logic [TOT_W-1:0]  total_clr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LEN_W-1:0]  mem_len_o,
  output logic [BUF_W-1:0]  mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [BUF_W-1:0]  mem_rdata_i,
  output logic              dst_req_o,
  input  logic              dst_ack_i,
  input  logic [ADDR_W-1:0] dst_next_addr_i,
  input  logic [SIZE_W-1:0] dst_next_size_i,
  input  logic              dst_next_intr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              src_done_o,
  output logic              dst_done_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [SIZE_W-1:0] src_rem_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [SIZE_W-1:0] dst_rem_o,
  output logic [TOT_W-1:0]  total_o
);
  import dma_chunk_pkg::*;

  chunk_state_e      state_q;
  logic [1:0]        mode_q;
  logic              fixed_q, mem_ptr_q, src_intr_q, dst_intr_q, dst_done_q;
  logic [ADDR_W-1:0] src_addr_q, dst_addr_q;
  logic [SIZE_W-1:0] src_rem_q, dst_rem_q;
  logic [LEN_W-1:0]  chunk_q, wr_left_q, dlen_q;
  logic [BUS_W-1:0]  pat_q;

  logic [1:0]        mode_eff;
  logic              fixed_eff, narrow;
  logic [LEN_W-1:0]  chunk_len, dlen_c;
  logic [SIZE_W-1:0] wr_left_ext, dst_eff;
  logic              need_fetch;

  // memory-held pointers force read-write with incrementing bursts
  assign mode_eff  = ptr_mem_i ? MODE_RW : mode_i;
  assign fixed_eff = ptr_mem_i ? 1'b0 : (burst_i == BURST_FIXED);
  assign narrow    = fixed_q || (mode_q == MODE_WO);

  dma_chunk_len #(
    .SIZE_W(SIZE_W), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES), .BUS_BYTES(BUS_BYTES)
  ) u_len (
    .rem_i(src_rem_q), .narrow_i(narrow), .len_o(chunk_len)
  );

  // register-held descriptors ignore destination size except in write-only mode
  assign wr_left_ext = SIZE_W'(wr_left_q);
  assign dst_eff     = (!mem_ptr_q && mode_q != MODE_WO) ? wr_left_ext : dst_rem_q;
  assign dlen_c      = (wr_left_ext <= dst_eff) ? wr_left_q : dst_eff[LEN_W-1:0];
  assign need_fetch  = mem_ptr_q && (dst_rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_RW;
      fixed_q    <= 1'b0;
      mem_ptr_q  <= 1'b0;
      src_intr_q <= 1'b0;
      dst_intr_q <= 1'b0;
      dst_done_q <= 1'b0;
      src_addr_q <= '0;
      dst_addr_q <= '0;
      src_rem_q  <= '0;
      dst_rem_q  <= '0;
      chunk_q    <= '0;
      wr_left_q  <= '0;
      dlen_q     <= '0;
      pat_q      <= '0;
    end else begin
      dst_done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q     <= mode_eff;
          fixed_q    <= fixed_eff;
          mem_ptr_q  <= ptr_mem_i;
          src_intr_q <= src_intr_i;
          dst_intr_q <= dst_intr_i;
          src_addr_q <= src_addr_i;
          dst_addr_q <= dst_addr_i;
          dst_rem_q  <= dst_size_i;
          src_rem_q  <= (mode_eff == MODE_WO) ? dst_size_i : src_size_i;
          pat_q      <= wo_data_i;
          state_q    <= ST_CHUNK;
        end
        ST_CHUNK: begin
          if (src_rem_q == '0) begin
            state_q <= ST_DONE;
          end else begin
            chunk_q   <= chunk_len;
            wr_left_q <= chunk_len;
            state_q   <= (mode_q == MODE_WO) ? ST_WCHK : ST_READ;
          end
        end
        ST_READ: if (mem_ack_i) begin
          if (!fixed_q) src_addr_q <= src_addr_q + ADDR_W'(chunk_q);
          state_q <= (mode_q == MODE_RO) ? ST_ACCT : ST_WCHK;
        end
        ST_WCHK: begin
          if (need_fetch) begin
            state_q <= ST_FETCH;
          end else begin
            dst_rem_q <= dst_eff;
            dlen_q    <= dlen_c;
            state_q   <= ST_WRITE;
          end
        end
        ST_FETCH: if (dst_ack_i) begin
          dst_addr_q <= dst_next_addr_i;
          dst_rem_q  <= dst_next_size_i;
          dst_intr_q <= dst_next_intr_i;
          state_q    <= ST_WCHK;
        end
        ST_WRITE: if (mem_ack_i) begin
          if (!fixed_q) dst_addr_q <= dst_addr_q + ADDR_W'(dlen_q);
          dst_rem_q  <= dst_rem_q - SIZE_W'(dlen_q);
          dst_done_q <= (dst_rem_q == SIZE_W'(dlen_q)) && dst_intr_q;
          wr_left_q  <= wr_left_q - dlen_q;
          state_q    <= (wr_left_q == dlen_q) ? ST_ACCT : ST_WCHK;
        end
        ST_ACCT: begin
          src_rem_q <= src_rem_q - SIZE_W'(chunk_q);
          state_q   <= ST_CHUNK;
        end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  dma_chunk_stage #(
    .BUF_BYTES(BUF_BYTES), .BUS_BYTES(BUS_BYTES), .LEN_W(LEN_W)
  ) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_rd_i   (state_q == ST_READ && mem_ack_i),
    .rd_data_i   (mem_rdata_i),
    .load_pat_i  (state_q == ST_CHUNK && src_rem_q != '0 && mode_q == MODE_WO),
    .pat_i       (pat_q),
    .shift_i     (state_q == ST_WRITE && mem_ack_i),
    .shift_len_i (dlen_q),
    .data_o      (mem_wdata_o)
  );

  dma_chunk_total #(.TOT_W(TOT_W), .LEN_W(LEN_W)) u_total (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (total_clr_i),
    .add_en_i (state_q == ST_ACCT),
    .add_i    (chunk_q),
    .total_o  (total_o)
  );

  assign mem_req_o  = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o   = (state_q == ST_WRITE);
  assign mem_addr_o = (state_q == ST_WRITE) ? dst_addr_q : src_addr_q;
  assign mem_len_o  = (state_q == ST_WRITE) ? dlen_q : chunk_q;
  assign dst_req_o  = (state_q == ST_FETCH);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign src_done_o = (state_q == ST_DONE) && src_intr_q;
  assign dst_done_o = dst_done_q;
  assign src_addr_o = src_addr_q;
  assign src_rem_o  = src_rem_q;
  assign dst_addr_o = dst_addr_q;
  assign dst_rem_o  = dst_rem_q;
endmodule

// File: rtl/dma_chunker_chk.sv
`timescale 1ns/1ps
module dma_chunker_chk #(
  parameter int ADDR_W    = 49,
  parameter int LEN_W     = 7,
  parameter int BUS_BYTES = 8,
  parameter int BUF_BYTES = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_i,
  input logic              mem_we_i,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic [LEN_W-1:0]  mem_len_i,
  input logic              dst_req_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              src_done_i,
  input logic [1:0]        mode_q_i,
  input logic              fixed_q_i
);
  assert_req_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_ack_i |=> mem_req_i && $stable(mem_addr_i) && $stable(mem_len_i) && $stable(mem_we_i));

  assert_len_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> (mem_len_i != '0) && (mem_len_i <= LEN_W'(BUF_BYTES)));

  assert_fixed_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && fixed_q_i |-> mem_len_i <= LEN_W'(BUS_BYTES));

  assert_wo_no_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && mode_q_i == 2'd1 |-> !(mem_req_i && !mem_we_i));

  assert_ro_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && mode_q_i == 2'd2 |-> !(mem_req_i && mem_we_i));

  assert_fetch_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dst_req_i && mem_req_i));

  assert_src_done_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_done_i |-> done_i);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
endmodule

bind dma_chunker dma_chunker_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES), .BUF_BYTES(BUF_BYTES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_i  (mem_req_o),
  .mem_we_i   (mem_we_o),
  .mem_ack_i  (mem_ack_i),
  .mem_addr_i (mem_addr_o),
  .mem_len_i  (mem_len_o),
  .dst_req_i  (dst_req_o),
  .busy_i     (busy_o),
  .done_i     (done_o),
  .src_done_i (src_done_o),
  .mode_q_i   (mode_q),
  .fixed_q_i  (fixed_q)
);

// File: tb/dma_chunker_bench.sv
`timescale 1ns/1ps
module dma_chunker_bench;
  localparam int ADDR_W = 49, SIZE_W = 30, TOT_W = 32;
  localparam int BUS_BYTES = 8, BUF_BYTES = 64;
  localparam int LEN_W = $clog2(BUF_BYTES + 1);
  localparam int BUS_W = BUS_BYTES * 8, BUF_W = BUF_BYTES * 8;
  localparam int NV = 8;
  localparam logic [63:0] PAT = 64'h8877_6655_4433_2211;

  typedef struct packed {
    logic [1:0]  mode;  logic burst; logic inmem;
    logic [15:0] sa;    logic [15:0] ss; logic si;
    logic [15:0] da;    logic [15:0] ds; logic di;
    logic [15:0] na;    logic [15:0] ns; logic ni;
    logic [7:0]  e_rd;  logic [7:0] e_wr; logic [7:0] e_ft;
    logic [15:0] e_tot; logic [7:0] e_dd; logic e_sd;
    logic [15:0] e_sa;  logic [15:0] e_da;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b1,1'b0, 16'h100,16'd20,1'b1, 16'h200,16'd0,1'b1, 16'h0,16'd0,1'b0,
      8'd1,8'd1,8'd0,16'd20,8'd1,1'b1, 16'h114,16'h214},
    '{2'd0,1'b1,1'b0, 16'h000,16'd150,1'b0, 16'h800,16'd0,1'b1, 16'h0,16'd0,1'b0,
      8'd3,8'd3,8'd0,16'd150,8'd3,1'b0, 16'h096,16'h896},
    '{2'd0,1'b0,1'b0, 16'h180,16'd20,1'b1, 16'h300,16'd0,1'b1, 16'h0,16'd0,1'b0,
      8'd3,8'd3,8'd0,16'd20,8'd3,1'b1, 16'h180,16'h300},
    '{2'd1,1'b1,1'b0, 16'h500,16'd100,1'b1, 16'h400,16'd20,1'b1, 16'h0,16'd0,1'b0,
      8'd0,8'd3,8'd0,16'd20,8'd1,1'b1, 16'h500,16'h414},
    '{2'd2,1'b1,1'b0, 16'h700,16'd70,1'b0, 16'h900,16'd0,1'b1, 16'h0,16'd0,1'b0,
      8'd2,8'd0,8'd0,16'd70,8'd0,1'b0, 16'h746,16'h900},
    '{2'd1,1'b0,1'b1, 16'h140,16'd20,1'b1, 16'hA80,16'd12,1'b1, 16'h600,16'd50,1'b1,
      8'd1,8'd2,8'd1,16'd20,8'd1,1'b1, 16'h154,16'h608},
    '{2'd0,1'b1,1'b1, 16'h1C0,16'd10,1'b0, 16'hB00,16'd0,1'b1, 16'h680,16'd10,1'b0,
      8'd1,8'd1,8'd1,16'd10,8'd0,1'b0, 16'h1CA,16'h68A},
    '{2'd0,1'b1,1'b0, 16'h040,16'd0,1'b1, 16'hA00,16'd0,1'b1, 16'h0,16'd0,1'b0,
      8'd0,8'd0,8'd0,16'd0,8'd0,1'b1, 16'h040,16'hA00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, burst = 1'b1, ptr_mem = 1'b0, src_intr = 1'b0, dst_intr = 1'b0;
  logic [1:0] mode = '0;
  logic [ADDR_W-1:0] src_addr = '0, dst_addr = '0, nxt_addr = '0;
  logic [SIZE_W-1:0] src_size = '0, dst_size = '0, nxt_size = '0;
  logic nxt_intr = 1'b0;
  logic [BUS_W-1:0] wo_data = PAT;
  logic [TOT_W-1:0] total_clr = '0;
  logic mem_req, mem_we, mem_ack = 1'b0, dst_req, dst_ack = 1'b0;
  logic [ADDR_W-1:0] mem_addr, dst_next_addr = '0;
  logic [LEN_W-1:0] mem_len;
  logic [BUF_W-1:0] mem_wdata, mem_rdata = '0;
  logic [SIZE_W-1:0] dst_next_size = '0;
  logic dst_next_intr = 1'b0;
  logic busy, done, src_done, dst_done;
  logic [ADDR_W-1:0] src_addr_o, dst_addr_o;
  logic [SIZE_W-1:0] src_rem_o, dst_rem_o;
  logic [TOT_W-1:0] total;

  logic [7:0] dmem [0:4095];
  int n_rd, n_wr, n_ft, n_done, n_sd, n_dd;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dma_chunker u_dma_chunker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .burst_i(burst),
    .ptr_mem_i(ptr_mem), .src_addr_i(src_addr), .src_size_i(src_size), .src_intr_i(src_intr),
    .dst_addr_i(dst_addr), .dst_size_i(dst_size), .dst_intr_i(dst_intr), .wo_data_i(wo_data),
    .total_clr_i(total_clr), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_len_o(mem_len), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .dst_req_o(dst_req), .dst_ack_i(dst_ack), .dst_next_addr_i(dst_next_addr),
    .dst_next_size_i(dst_next_size), .dst_next_intr_i(dst_next_intr), .busy_o(busy),
    .done_o(done), .src_done_o(src_done), .dst_done_o(dst_done), .src_addr_o(src_addr_o),
    .src_rem_o(src_rem_o), .dst_addr_o(dst_addr_o), .dst_rem_o(dst_rem_o), .total_o(total)
  );

  function automatic logic [7:0] src_byte(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // memory, fetcher and event monitor, all acting on the falling edge
  initial begin
    for (int i = 0; i < 4096; i++) dmem[i] = 8'h00;
    forever begin
      @(negedge clk);
      if (done) n_done++;
      if (src_done) n_sd++;
      if (dst_done) n_dd++;
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (mem_we) begin
          for (int i = 0; i < BUF_BYTES; i++)
            if (i < int'(mem_len)) dmem[12'(mem_addr + ADDR_W'(i))] = mem_wdata[8*i +: 8];
          n_wr++;
        end else begin
          for (int i = 0; i < BUF_BYTES; i++)
            mem_rdata[8*i +: 8] = (i < int'(mem_len)) ? src_byte(mem_addr + ADDR_W'(i)) : 8'h00;
          n_rd++;
        end
        mem_ack = 1'b1;
      end
      if (dst_ack) dst_ack = 1'b0;
      else if (dst_req) begin
        dst_next_addr = nxt_addr;
        dst_next_size = nxt_size;
        dst_next_intr = nxt_intr;
        n_ft++;
        dst_ack = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic clear_total();
    total_clr = '1; tick(); total_clr = '0;
  endtask

  task automatic run(input vec_t v);
    int t;
    n_rd = 0; n_wr = 0; n_ft = 0; n_done = 0; n_sd = 0; n_dd = 0;
    mode = v.mode; burst = v.burst; ptr_mem = v.inmem;
    src_addr = ADDR_W'(v.sa); src_size = SIZE_W'(v.ss); src_intr = v.si;
    dst_addr = ADDR_W'(v.da); dst_size = SIZE_W'(v.ds); dst_intr = v.di;
    nxt_addr = ADDR_W'(v.na); nxt_size = SIZE_W'(v.ns); nxt_intr = v.ni;
    start = 1'b1; tick(); start = 1'b0;
    t = 0;
    while (n_done == 0 && t < 3000) begin tick(); t++; end
    if (t >= 3000) chk(1'b0, "watchdog", t, 0);
    tick();
  endtask

  initial begin
    int bad;
    repeat (3) tick();
    // R11: idle after reset
    chk(!busy && !mem_req && !dst_req, "R11 idle", {busy, mem_req, dst_req}, 0);
    chk(total == '0, "R11 total", total, 0);
    chk(!done && !src_done && !dst_done, "R11 events", {done, src_done, dst_done}, 0);
    rst_n = 1'b1;
    tick();
    chk(!busy && total == '0, "R11 after release", total, 0);

    for (int k = 0; k < NV; k++) begin
      clear_total();
      run(VECS[k]);
      // R1 R3 R4 R6: transaction counts
      chk(n_rd == int'(VECS[k].e_rd), $sformatf("R1/R4 reads v%0d", k), n_rd, VECS[k].e_rd);
      chk(n_wr == int'(VECS[k].e_wr), $sformatf("R3/R5 writes v%0d", k), n_wr, VECS[k].e_wr);
      chk(n_ft == int'(VECS[k].e_ft), $sformatf("R7 fetches v%0d", k), n_ft, VECS[k].e_ft);
      chk(total == TOT_W'(VECS[k].e_tot), $sformatf("R8 total v%0d", k), total, VECS[k].e_tot);
      chk(n_dd == int'(VECS[k].e_dd), $sformatf("R5/R7 dst_done v%0d", k), n_dd, VECS[k].e_dd);
      chk(n_done == 1 && n_sd == int'(VECS[k].e_sd), $sformatf("R9 done v%0d", k), n_sd, VECS[k].e_sd);
      chk(src_addr_o == ADDR_W'(VECS[k].e_sa), $sformatf("R2/R6 src addr v%0d", k), src_addr_o, VECS[k].e_sa);
      chk(dst_addr_o == ADDR_W'(VECS[k].e_da), $sformatf("R2/R6 dst addr v%0d", k), dst_addr_o, VECS[k].e_da);
      if (k == 0 || k == 1) begin
        bad = 0;
        for (int i = 0; i < int'(VECS[k].ss); i++)
          if (dmem[12'(VECS[k].da + 16'(i))] != src_byte(ADDR_W'(VECS[k].sa) + ADDR_W'(i))) bad++;
        chk(bad == 0, $sformatf("R10 data v%0d", k), bad, 0);
      end
      if (k == 3) begin
        bad = 0;
        for (int i = 0; i < 20; i++)
          if (dmem[12'(16'h400 + 16'(i))] != PAT[8*(i%8) +: 8]) bad++;
        chk(bad == 0, "R3 pattern data", bad, 0);
      end
      if (k == 5) chk(dst_rem_o == SIZE_W'(42), "R7 dst remaining", dst_rem_o, 42);
    end

    // R8: partial write-one-to-clear, zero mask holds
    clear_total();
    run(VECS[0]);
    total_clr = TOT_W'(4); tick(); total_clr = '0;
    chk(total == TOT_W'(16), "R8 w1c partial", total, 16);
    repeat (3) tick();
    chk(total == TOT_W'(16), "R8 zero mask holds", total, 16);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule